// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the byte a host sees when it reads a flash array while an embedded program or erase is running, suspended or stuck past its limit. A command decoder and an embedded algorithm engine elsewhere in the device supply the operation kind, the busy, suspended and timeout flags, the byte being programmed, the set of sectors chosen for erase, and the erase-window state. For every host read, the block either passes the array byte straight through or replaces it with a status byte.

The status byte carries five live bits. Bit 7 is a data-polling bit. Bit 6 is a toggle bit that reports whether the engine is running. Bit 5 reports a timeout. Bit 3 shows that the erase acceptance window has closed. Bit 2 is a second toggle bit that marks sectors chosen for erase. Bits 4, 1 and 0 read 0. Both toggle bits advance once per host read, on the rising edge of the read strobe, and not with time. A host can therefore tell whether an operation is running by comparing two reads in a row. The command decoder pulses `op_start` on the write that launches an operation, which is the final write of the command sequence. This clears both toggle bits.

Top module: `flash_status_gen`

## Requirements
- R1: When busy, suspended and timeout are all low, `data_out` equals `array_data` and `status_sel` is 0.
- R2: During a program (`op_erase`=0, busy=1), bit 7 of the status byte is the inverse of bit 7 of `prog_data`.
- R3: During an erase with busy=1, bit 7 reads 0. During a suspended erase (busy=0, suspended=1), a read of a chosen sector gives bit 7 = 1.
- R4: While busy or timeout is high, bit 6 inverts once for each rising edge of `rd_strobe`, whatever the read sector. A strobe held high for several clocks counts as one read.
- R5: While busy and timeout are both low (including an erase suspend), bit 6 keeps its value across reads.
- R6: Bit 2 inverts on a read strobe only during an erase (busy or suspended) and only when bit `rd_sector` of `sector_mask` is 1. Reads of other sectors leave it unchanged.
- R7: During a suspended erase, a read of a sector whose mask bit is 0 returns `array_data` with `status_sel`=0.
- R8: Bit 5 equals the timeout flag. While timeout is high, the status byte is shown even after busy drops, and bit 6 keeps toggling.
- R9: Bit 3 is 1 only during a busy erase whose window is closed (`erase_window`=0). Otherwise it is 0, including during any program.
- R10: Reset and a pulse on `op_start` both clear the two toggle bits to 0. If `op_start` falls in the same clock as a read-strobe rise, the clear takes priority.
- R11: A program issued during an erase suspend (`op_erase`=0, busy=1, suspended=1) behaves as a normal program: bit 7 is the inverse of the data and bit 6 toggles.
- R12: Status bits 4, 1 and 0 always read 0. During a program, bit 2 does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when a new operation is launched |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| busy | input | 1 | Embedded algorithm running |
| suspended | input | 1 | Erase suspended |
| timeout | input | 1 | Operation exceeded its pulse-count limit |
| erase_window | input | 1 | 1 while further erase sector loads are still accepted |
| prog_data | input | 8 | Byte being programmed |
| sector_mask | input | NSEC | One bit per sector chosen for erase |
| rd_sector | input | SECW | Sector index of the current read address |
| rd_strobe | input | 1 | Host read strobe, high during a read |
| array_data | input | 8 | Byte read from the array |
| data_out | output | 8 | Byte returned to the host |
| status_sel | output | 1 | 1 when `data_out` carries status |

## Verification
The assertions assume that `op_start` lasts one clock, and that the operation kind, sector mask and read sector stay steady while a strobe is high. They also assume that timeout is only raised alongside an operation, and that suspended with busy marks a program nested inside a suspended erase. The stimulus changes these inputs only at the falling clock edge between reads. It holds them fixed across every strobe pulse, and it pulses `op_start` alone for one clock, except in the one deliberate same-cycle collision.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int NSEC = 11,
  parameter int SECW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic            op_erase,
  input  logic            busy,
  input  logic            suspended,
  input  logic            timeout,
  input  logic            erase_window,
  input  logic [7:0]      prog_data,
  input  logic [NSEC-1:0] sector_mask,
  input  logic [SECW-1:0] rd_sector,
  input  logic            rd_strobe,
  input  logic [7:0]      array_data,
  output logic [7:0]      data_out,
  output logic            status_sel
);

  localparam int PADW = 1 << SECW;

  logic            rd_q;
  logic            rd_rise;
  logic            tog_run;
  logic            tog_sec;
  logic [PADW-1:0] mask_pad;
  logic            sec_hit;
  logic            run_en;
  logic            sec_en;
  logic            poll_bit;
  logic            win_bit;
  logic [7:0]      stat_byte;

  assign mask_pad = PADW'(sector_mask);
  assign sec_hit  = mask_pad[rd_sector];
  assign rd_rise  = rd_strobe & ~rd_q;
  assign run_en   = busy | timeout;
  assign sec_en   = op_erase & (busy | suspended) & sec_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      tog_run <= 1'b0;
      tog_sec <= 1'b0;
    end else begin
      rd_q <= rd_strobe;
      if (op_start) begin
        tog_run <= 1'b0;
        tog_sec <= 1'b0;
      end else if (rd_rise) begin
        if (run_en) tog_run <= ~tog_run;
        if (sec_en) tog_sec <= ~tog_sec;
      end
    end
  end

  assign poll_bit   = op_erase ? (suspended & ~busy) : ~prog_data[7];
  assign win_bit    = op_erase & busy & ~erase_window;
  assign stat_byte  = {poll_bit, tog_run, timeout, 1'b0, win_bit, tog_sec, 2'b00};
  assign status_sel = busy | timeout | (op_erase & suspended & sec_hit);
  assign data_out   = status_sel ? stat_byte : array_data;

  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !suspended && !timeout) |-> (data_out == array_data && !status_sel));

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_erase) |-> (data_out[7] == !prog_data[7]));

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_erase) |-> !data_out[7]);

  assert_run_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe && !rd_q && !op_start) |=> (tog_run != $past(tog_run)));

  assert_run_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !timeout && !op_start) |=> $stable(tog_run));

  assert_timeout_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> (data_out[5] == timeout));

  assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!tog_run && !tog_sec));

  assert_zero_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> (data_out[4] == 1'b0 && data_out[1:0] == 2'b00));

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int NSEC = 11;
  localparam int SECW = 4;
  localparam int NV   = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 1'b0, op_erase = 1'b0, busy = 1'b0, suspended = 1'b0;
  logic timeout = 1'b0, erase_window = 1'b0, rd_strobe = 1'b0;
  logic [7:0] prog_data = 8'hA5;
  logic [7:0] array_data = 8'h3C;
  logic [NSEC-1:0] sector_mask = 11'b00000100100;
  logic [SECW-1:0] rd_sector = '0;
  logic [7:0] data_out;
  logic status_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_status_gen #(.NSEC(NSEC), .SECW(SECW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .busy(busy), .suspended(suspended), .timeout(timeout),
    .erase_window(erase_window), .prog_data(prog_data),
    .sector_mask(sector_mask), .rd_sector(rd_sector), .rd_strobe(rd_strobe),
    .array_data(array_data), .data_out(data_out), .status_sel(status_sel)
  );

  // {start, erase, busy, susp, tmo, win, sector[3:0], read, exp_sel, exp_byte[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'h3C},
    {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,8'h00},
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,8'h40},
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd5,1'b1,1'b1,8'h00},
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,8'h40},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'h3C},
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'd0,1'b0,1'b1,8'h00},
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'd2,1'b1,1'b1,8'h44},
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,8'h0C},
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd5,1'b1,1'b1,8'h48},
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd2,1'b1,1'b1,8'hC4},
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd0,1'b1,1'b0,8'h3C},
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd5,1'b1,1'b1,8'hC0},
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,4'd2,1'b1,1'b1,8'h40},
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd5,1'b1,1'b1,8'h00},
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd2,1'b1,1'b1,8'h84},
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,8'h4C},
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'd2,1'b1,1'b1,8'h28},
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,8'h60},
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'h3C},
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,8'h60}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 5, 19:   return "R1";
      1:          return "R2";
      2, 4:       return "R4";
      3:          return "R12";
      6:          return "R10";
      7, 9, 12:   return "R6";
      8, 16:      return "R9";
      10:         return "R3";
      11:         return "R7";
      13, 14:     return "R11";
      15:         return "R5";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic esel, input logic [7:0] eb);
    checks++;
    if (status_sel !== esel || data_out !== eb) begin
      errors++;
      $display("FAIL %s: got sel=%0b data=%02h, expected sel=%0b data=%02h",
               tag, status_sel, data_out, esel, eb);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) op_start = 1'b1;
    @(negedge clk) op_start = 1'b0;
  endtask

  task automatic host_read(input int hold);
    @(negedge clk) rd_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    busy = 1'b1;
    #1 check("R2", 1'b1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_erase     = VEC[i][18];
      busy         = VEC[i][17];
      suspended    = VEC[i][16];
      timeout      = VEC[i][15];
      erase_window = VEC[i][14];
      rd_sector    = VEC[i][13:10];
      if (VEC[i][19]) pulse_start();
      if (VEC[i][9]) host_read(1);
      #1 check(tag_of(i), VEC[i][8], VEC[i][7:0]);
    end

    @(negedge clk);
    op_erase = 1'b0; busy = 1'b1; suspended = 1'b0; timeout = 1'b0; rd_sector = 4'd0;
    pulse_start();
    host_read(4);
    #1 check("R4", 1'b1, 8'h40);

    @(negedge clk);
    op_start = 1'b1; rd_strobe = 1'b1;
    @(negedge clk);
    op_start = 1'b0; rd_strobe = 1'b0;
    #1 check("R10", 1'b1, 8'h00);

    @(negedge clk);
    op_erase = 1'b1; busy = 1'b0; suspended = 1'b1; rd_sector = 4'd9;
    host_read(1);
    #1 check("R7", 1'b0, 8'h3C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule